// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two direction components and a chooser. The first component is a table of 2-bit saturating counters addressed only by the branch address. The second is a correlating table. Its address joins low branch-address bits with a short register of the most recent resolved outcomes, so each history pattern seen by a branch gets its own counter. A third table of 2-bit chooser counters, also addressed by branch address, decides per branch which component's guess is given out.

Fetch presents a PC on the lookup port. The prediction, the component that was picked and the current history come back combinationally in the same cycle. Later, the resolution logic returns the PC, the real outcome and the history value that was captured at lookup. On the next clock edge the block trains both components and the chooser, and shifts the outcome into the history register.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every direction counter holds 2'b01 (weakly not-taken), every chooser counter holds 2'b01 (weakly favour-local) and the history is all zeros. Every lookup therefore returns predTaken=0 and predUsedGlobal=0.
- R2: Lookup is combinational. predTaken is the upper bit of the counter in the selected component. predUsedGlobal is 1 exactly when the chooser entry's upper bit is 1 (chooser encodings: 00 strong local, 01 weak local, 10 weak global, 11 strong global).
- R3: On an update each addressed direction counter steps up by one on a taken outcome and down by one on a not-taken outcome, saturating at 2'b11 and 2'b00. From a strong state the predicted direction therefore changes only after two opposite outcomes in a row.
- R4: The local component and the chooser are addressed by PC[IDX_W+1:2]. PC[1:0] and the PC bits above IDX_W+1 have no effect on the prediction.
- R5: The correlating component is addressed by {PC[IDX_W-HIST_W+1:2], history}, with the history in the low HIST_W bits. Each history pattern thus selects a distinct counter for the same branch.
- R6: The chooser steps one place toward global when only the correlating component was right, and one place toward local when only the local component was right, saturating at both ends. It does not move when both components were right or both were wrong.
- R7: Every update shifts the resolved outcome into bit 0 of the history and drops the oldest bit. Without an update the history holds its value.
- R8: Training of the correlating component uses the history snapshot supplied with the update, not the live history.
- R9: An update changes nothing visible in the cycle it is presented. Its effect appears from the following clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupPc | input | PC_W | Fetch address being predicted |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predUsedGlobal | output | 1 | 1 when the correlating component supplied the prediction |
| curHist | output | HIST_W | Live outcome history, for the fetch unit to keep with the branch |
| updValid | input | 1 | A resolved branch is being reported |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Real outcome of the resolved branch |
| updHist | input | HIST_W | History captured when that branch was predicted |

## Verification
The bench builds the block with IDX_W=4, HIST_W=2 and PC_W=8. This gives 16 entries per table, four history patterns and two spare PC bits above and below the index field. After every update the bench sweeps all 16 index values, with random spare bits, against its own model of the tables. That sweep reaches every counter saturation, every chooser transition and every history pattern within a few thousand updates. The update stream mixes outcomes that follow history with outcomes that follow the branch address, so the two components disagree often. About one update in eight carries a stale history snapshot to exercise training with a snapshot that differs from the live history.

// File: rtl/tourney_pkg.sv
package tourney_pkg;

  typedef struct packed {
    logic wrDir;      // train both direction counters
    logic dirUp;      // direction of that training step
    logic wrChoose;   // move the chooser entry
    logic chooseUp;   // 1 = toward global, 0 = toward local
    logic shiftHist;  // shift an outcome into the history
    logic histBit;    // the outcome shifted in
  } updStrobes_t;

  localparam logic [1:0] CTR_WEAK_NT    = 2'b01;
  localparam logic [1:0] CHOOSE_WEAK_LO = 2'b01;

  function automatic logic [1:0] satStep(input logic [1:0] ctr, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (ctr == 2'b11) ? ctr : ctr + 2'b01;
    else    nxt = (ctr == 2'b00) ? ctr : ctr - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/tourney_ctrl.sv
module tourney_ctrl
  import tourney_pkg::*;
(
  input  logic        updValid,
  input  logic        updTaken,
  input  logic        updLocalPred,
  input  logic        updGlobalPred,
  output updStrobes_t strb
);

  logic localRight;
  logic globalRight;

  always_comb begin
    localRight  = (updLocalPred == updTaken);
    globalRight = (updGlobalPred == updTaken);

    strb.wrDir     = updValid;
    strb.dirUp     = updTaken;
    strb.wrChoose  = updValid & (localRight ^ globalRight);
    strb.chooseUp  = globalRight;
    strb.shiftHist = updValid;
    strb.histBit   = updTaken;
  end

endmodule

// File: rtl/tourney_datapath.sv
module tourney_datapath
  import tourney_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [PC_W-1:0]   updPc,
  input  logic [HIST_W-1:0] updHist,
  input  updStrobes_t       strb,
  output logic              predTaken,
  output logic              predUsedGlobal,
  output logic [HIST_W-1:0] curHist,
  output logic              updLocalPred,
  output logic              updGlobalPred
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int PCF_W   = IDX_W - HIST_W;
  localparam int PC_LO   = 2;

  logic [1:0] localTbl  [ENTRIES];
  logic [1:0] globalTbl [ENTRIES];
  logic [1:0] chooseTbl [ENTRIES];
  logic [HIST_W-1:0] histQ;

  logic [IDX_W-1:0] lkLocalIdx, lkGlobalIdx;
  logic [IDX_W-1:0] upLocalIdx, upGlobalIdx;

  logic unusedPcBits;
  assign unusedPcBits = ^{lookupPc[PC_W-1:IDX_W+PC_LO], lookupPc[PC_LO-1:0],
                          updPc[PC_W-1:IDX_W+PC_LO], updPc[PC_LO-1:0]};

  // index formation
  always_comb begin
    lkLocalIdx  = lookupPc[PC_LO +: IDX_W];
    upLocalIdx  = updPc[PC_LO +: IDX_W];
    lkGlobalIdx = {lookupPc[PC_LO +: PCF_W], histQ};
    upGlobalIdx = {updPc[PC_LO +: PCF_W], updHist};
  end

  // lookup path
  always_comb begin
    predUsedGlobal = chooseTbl[lkLocalIdx][1];
    predTaken      = predUsedGlobal ? globalTbl[lkGlobalIdx][1]
                                    : localTbl[lkLocalIdx][1];
    updLocalPred   = localTbl[upLocalIdx][1];
    updGlobalPred  = globalTbl[upGlobalIdx][1];
  end

  assign curHist = histQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) localTbl[i] <= CTR_WEAK_NT;
    end else if (strb.wrDir) begin
      localTbl[upLocalIdx] <= satStep(localTbl[upLocalIdx], strb.dirUp);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) globalTbl[i] <= CTR_WEAK_NT;
    end else if (strb.wrDir) begin
      globalTbl[upGlobalIdx] <= satStep(globalTbl[upGlobalIdx], strb.dirUp);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) chooseTbl[i] <= CHOOSE_WEAK_LO;
    end else if (strb.wrChoose) begin
      chooseTbl[upLocalIdx] <= satStep(chooseTbl[upLocalIdx], strb.chooseUp);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) histQ <= '0;
    else if (strb.shiftHist) histQ <= HIST_W'({histQ, strb.histBit});
  end

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tourney_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   lookupPc,
  output logic              predTaken,
  output logic              predUsedGlobal,
  output logic [HIST_W-1:0] curHist,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic              updTaken,
  input  logic [HIST_W-1:0] updHist
);

  updStrobes_t strb;
  logic        updLocalPred;
  logic        updGlobalPred;

  tourney_ctrl u_ctrl (
    .updValid      (updValid),
    .updTaken      (updTaken),
    .updLocalPred  (updLocalPred),
    .updGlobalPred (updGlobalPred),
    .strb          (strb)
  );

  tourney_datapath #(
    .PC_W   (PC_W),
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .lookupPc       (lookupPc),
    .updPc          (updPc),
    .updHist        (updHist),
    .strb           (strb),
    .predTaken      (predTaken),
    .predUsedGlobal (predUsedGlobal),
    .curHist        (curHist),
    .updLocalPred   (updLocalPred),
    .updGlobalPred  (updGlobalPred)
  );

endmodule

// File: rtl/tourney_predictor_chk.sv
module tourney_predictor_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   lookupPc,
  input logic              predTaken,
  input logic              predUsedGlobal,
  input logic [HIST_W-1:0] curHist,
  input logic              updValid,
  input logic              updTaken
);

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> curHist == HIST_W'({$past(curHist), $past(updTaken)})); // R7

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(curHist)); // R7

  AST_PRED_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !updValid ##1 $stable(lookupPc) |-> $stable(predTaken) && $stable(predUsedGlobal)); // R9

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> curHist == '0 && !predTaken && !predUsedGlobal); // R1

  AST_KNOWN_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({predTaken, predUsedGlobal, curHist})); // R2

endmodule

bind tourney_predictor tourney_predictor_chk #(
  .PC_W   (PC_W),
  .HIST_W (HIST_W)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .lookupPc       (lookupPc),
  .predTaken      (predTaken),
  .predUsedGlobal (predUsedGlobal),
  .curHist        (curHist),
  .updValid       (updValid),
  .updTaken       (updTaken)
);

// File: tb/sim_tourney_predictor.sv
`timescale 1ns/1ps
module sim_tourney_predictor;

  localparam int PC_W   = 8;
  localparam int IDX_W  = 4;
  localparam int HIST_W = 2;
  localparam int ENT    = 1 << IDX_W;
  localparam int PCF    = 1 << (IDX_W - HIST_W);
  localparam int HMASK  = (1 << HIST_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [PC_W-1:0]   lookupPc = '0;
  logic              predTaken;
  logic              predUsedGlobal;
  logic [HIST_W-1:0] curHist;
  logic              updValid = 1'b0;
  logic [PC_W-1:0]   updPc = '0;
  logic              updTaken = 1'b0;
  logic [HIST_W-1:0] updHist = '0;

  always #2 clk = ~clk;

  tourney_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u0 (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predTaken),
    .predUsedGlobal(predUsedGlobal), .curHist(curHist), .updValid(updValid),
    .updPc(updPc), .updTaken(updTaken), .updHist(updHist)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  int mLoc [ENT];
  int mGlb [ENT];
  int mChs [ENT];
  int mHist;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int sat(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic int gIdx(int idx, int h);
    return ((idx % PCF) << HIST_W) | (h & HMASK);
  endfunction

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic check(string tag, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // sweep every index with random spare PC bits; compare against the model
  task automatic sweep(string tag);
    for (int i = 0; i < ENT; i++) begin
      stepLfsr();
      lookupPc = {lfsr[1:0], i[IDX_W-1:0], lfsr[3:2]};
      #0.1;
      begin
        int useG = mChs[i] >> 1;
        int expT = useG ? (mGlb[gIdx(i, mHist)] >> 1) : (mLoc[i] >> 1);
        check(tag, int'(predUsedGlobal), useG, "chooser select");
        check(tag, int'(predTaken), expT, "direction");
      end
    end
    check("R7", int'(curHist), mHist, "history");
  endtask

  // present one update at a negedge, apply it at the next posedge
  task automatic doUpdate(int idx, bit taken, int h);
    int li, gi, lp, gp;
    updValid = 1'b1;
    stepLfsr();
    updPc    = {lfsr[5:4], idx[IDX_W-1:0], lfsr[7:6]};
    updTaken = taken;
    updHist  = h[HIST_W-1:0];
    lookupPc = updPc;
    #0.2;
    // R9: nothing visible changes before the edge
    begin
      int useG = mChs[idx] >> 1;
      check("R9", int'(predTaken),
            useG ? (mGlb[gIdx(idx, mHist)] >> 1) : (mLoc[idx] >> 1), "pre-edge direction");
      check("R9", int'(curHist), mHist, "pre-edge history");
    end
    @(posedge clk);
    li = idx; gi = gIdx(idx, h);
    lp = mLoc[li] >> 1; gp = mGlb[gi] >> 1;
    mLoc[li] = sat(mLoc[li], taken);
    mGlb[gi] = sat(mGlb[gi], taken);
    if ((lp == int'(taken)) != (gp == int'(taken)))
      mChs[li] = sat(mChs[li], gp == int'(taken));
    mHist = ((mHist << 1) | int'(taken)) & HMASK;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin mLoc[i] = 1; mGlb[i] = 1; mChs[i] = 1; end
    mHist = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    sweep("R1");

    // R3: saturation and two-in-a-row flip on one branch, fixed snapshot
    for (int k = 0; k < 4; k++) begin doUpdate(5, 1'b1, 0); sweep("R3"); end
    doUpdate(5, 1'b0, 0); sweep("R3");
    doUpdate(5, 1'b0, 0); sweep("R3");
    for (int k = 0; k < 4; k++) begin doUpdate(5, 1'b0, 0); sweep("R3"); end

    // R5/R8: same branch trained under every history snapshot
    for (int h = 0; h <= HMASK; h++) begin
      doUpdate(9, h[0], h); sweep("R5");
      doUpdate(9, h[0], h); sweep("R8");
    end

    // R6/R2/R4: mixed stream, history-correlated and address-correlated branches
    for (int n = 0; n < 2500; n++) begin
      int idx, h;
      bit t;
      stepLfsr();
      idx = int'(lfsr[3:0]) % ENT;
      if (idx % 2 == 0) t = mHist[0] ^ mHist[1];
      else              t = idx[1];
      if (lfsr[6:4] == 3'd0) t = ~t;
      h = (lfsr[9:7] == 3'd0) ? int'(lfsr[11:10]) : mHist;
      doUpdate(idx, t, h);
      if (n % 4 == 0) sweep("R6");
      else if (n % 4 == 1) sweep("R4");
      else if (n % 4 == 2) sweep("R8");
      else sweep("R2");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule